// File: doc/BRIEF.md
# Framed Serial Port Receiver

This block takes serial data that arrives on a bit clock, qualified by a frame-sync input, and turns it into parallel words. The bit clock is presented as `bit_tick`, a one-cycle strobe that is synchronous to the system clock. The frame-sync and data inputs are sampled only on cycles where `bit_tick` is high. A frame is made of one or two phases. Each phase has its own word length and its own word count. The first data bit can be taken zero, one or two bit clocks after the frame-sync pulse.

Every completed word moves from the shift register into a one-word buffer stage, and from there into the read register. On the way into the read register it is justified and extended according to `just_mode`. The read register is offered on a valid/ready output:
- `rd_valid` stays high, and `rd_data` holds still, until the consumer asserts `rd_ready`. The word is taken on the cycle where both are high.
- Back-pressure is absorbed by the buffer stage.
- When the buffer is also full, a further completed word is lost and the overrun flag is raised.

A sticky sync-error flag records frame syncs that arrive in the middle of a frame. A single registered interrupt output takes its source from a selectable condition. Software holds the receiver in reset by driving `rx_en` low.

Top module: `fsp_rx`

## Requirements
- R1: While `rx_en` is 0, the receiver ignores `bit_tick`, `fsync_in` and `sdata_in`. On the next clock edge it clears `rd_valid`, `overrun` and `sync_err`, and any word held in the buffer or the read register is discarded.
- R2: Words are shifted in MSB first. The word-length code of each phase selects the number of bits: 0=8, 1=12, 2=16, 3=20, 4=24, and 5, 6 or 7 = 32. The received bits sit at the low end of a 32-bit word before justification.
- R3: A phase holds `flen_code`+1 words (1 to 128). After the last word of the frame, the receiver waits for a new frame sync, and serial bits received in between produce no word.
- R4: With `dual_phase`=1, the phase-1 words are followed without a gap by the phase-2 words. Phase 2 uses `wlen2_code` and `flen2_code`. With `dual_phase`=0, only phase 1 exists.
- R5: The first data bit is sampled on the tick that carries the frame sync when `delay_code`=0, one tick later when it is 1, and two ticks later when it is 2. Code 3 acts as 2.
- R6: With `frame_ignore`=1, a frame sync that arrives while a frame is in progress has no effect: the frame's words are received intact and `sync_err` stays 0.
- R7: With `frame_ignore`=0, a frame sync that arrives mid-frame discards the partial word, starts a new frame on that tick and sets `sync_err`. `sync_err` stays set until a cycle with `sync_err_clr`=1, and a new set wins over a clear in the same cycle.
- R8: `just_mode` sets how the read register is filled:
  - 0: right-justify and zero-fill.
  - 1: right-justify and sign-extend from the word's top bit.
  - 2: left-justify and zero-fill the low bits.
  - 3: acts as 0.
- R9: `rd_valid` and `rd_data` hold until a cycle with `rd_valid` and `rd_ready` both high, which empties the read register. A word waiting in the buffer enters the read register on the cycle after it empties.
- R10: When a word completes while both the read register and the buffer are occupied, that word is dropped and `overrun` is set. `overrun` clears on the next read handshake.
- R11: `irq` is registered and follows its selected source one cycle later:
  - `irq_sel`=0: the source is `rd_valid`.
  - `irq_sel`=1: `irq` is held at 0.
  - `irq_sel`=2: one pulse per accepted frame sync.
  - `irq_sel`=3: the source is `sync_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 holds it in reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit clock |
| fsync_in | input | 1 | Frame-sync input, sampled on `bit_tick` |
| sdata_in | input | 1 | Serial data input, sampled on `bit_tick` |
| dual_phase | input | 1 | 1 selects a two-phase frame |
| wlen1_code | input | 3 | Word-length code, phase 1 |
| wlen2_code | input | 3 | Word-length code, phase 2 |
| flen1_code | input | 7 | Words in phase 1 minus one |
| flen2_code | input | 7 | Words in phase 2 minus one |
| delay_code | input | 2 | Data delay after frame sync, in bits |
| frame_ignore | input | 1 | 1 ignores mid-frame frame syncs |
| just_mode | input | 2 | Justification and extension mode |
| irq_sel | input | 2 | Interrupt source select |
| sync_err_clr | input | 1 | Clears the sync-error flag |
| rd_valid | output | 1 | Read register holds a word |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | 32 | Justified read register |
| overrun | output | 1 | A word was lost to a full pipeline |
| sync_err | output | 1 | Sticky mid-frame sync flag |
| irq | output | 1 | Interrupt output |

## Verification
**Data delay.** Delay slots are filled with ones. A receiver that samples one tick early, or one tick late, would return a visibly different byte.

**Justification.** Sign extension is tried on both a negative 12-bit word and a positive 20-bit word, and left justification on 8-bit and 16-bit words. These catch an off-by-one in the extension index or the shift amount.

**Mid-frame frame sync.** Both settings of `frame_ignore` are exercised:
- A design that restarted on an ignored sync would lose the second word.
- A design that kept the partial word after a restart would shift every following byte.

**Pipeline full, frame end and disable.**
- Three unread words must leave the first two readable, lose the third and raise `overrun`.
- Idle bits after a frame must produce nothing.
- Dropping `rx_en` must discard a held word.

// File: rtl/fsp_rx_pkg.sv
package fsp_rx_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_DELAY = 2'd1,
    FR_DATA  = 2'd2
  } fr_state_t;

  typedef enum logic [1:0] {
    JM_RIGHT_ZERO = 2'd0,
    JM_RIGHT_SIGN = 2'd1,
    JM_LEFT_ZERO  = 2'd2,
    JM_SPARE      = 2'd3
  } just_mode_t;

  typedef enum logic [1:0] {
    IRQ_READY = 2'd0,
    IRQ_NONE  = 2'd1,
    IRQ_FRAME = 2'd2,
    IRQ_SYNC  = 2'd3
  } irq_src_t;

  // Number of bits carried by a word-length code; spare codes give 32.
  function automatic logic [5:0] code_to_bits(input logic [2:0] code);
    case (code)
      3'd0:    code_to_bits = 6'd8;
      3'd1:    code_to_bits = 6'd12;
      3'd2:    code_to_bits = 6'd16;
      3'd3:    code_to_bits = 6'd20;
      3'd4:    code_to_bits = 6'd24;
      default: code_to_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/fsp_rx_framer.sv
module fsp_rx_framer
  import fsp_rx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FLEN_W  = 7,
  parameter int WCODE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               bit_tick,
  input  logic               fsync_in,
  input  logic               sdata_in,
  input  logic               dual_phase,
  input  logic [WCODE_W-1:0] wlen1_code,
  input  logic [WCODE_W-1:0] wlen2_code,
  input  logic [FLEN_W-1:0]  flen1_code,
  input  logic [FLEN_W-1:0]  flen2_code,
  input  logic [1:0]         delay_code,
  input  logic               frame_ignore,
  output logic               word_done,
  output logic [DATA_W-1:0]  word_data,
  output logic [WCODE_W-1:0] word_code,
  output logic               frame_start,
  output logic               sync_hit
);

  localparam int BCNT_W = $clog2(DATA_W + 1);

  fr_state_t           state_q;
  logic [1:0]          skip_q;
  logic [BCNT_W-1:0]   bits_q;
  logic [FLEN_W-1:0]   words_q;
  logic                phase_q;
  logic [DATA_W-1:0]   shreg_q;

  logic                in_frame, start, take;
  logic [1:0]          eff_delay;
  logic                b_phase;
  logic [FLEN_W-1:0]   b_words;
  logic [BCNT_W-1:0]   b_bits;
  logic [DATA_W-1:0]   b_sh, sh_n;
  logic [WCODE_W-1:0]  cur_code;
  logic [FLEN_W-1:0]   cur_flen;
  logic [BCNT_W-1:0]   cur_len;
  logic                last_bit, last_word, last_phase;

  always_comb begin
    in_frame  = (state_q != FR_IDLE);
    eff_delay = (delay_code == 2'd3) ? 2'd2 : delay_code;
    start     = bit_tick && fsync_in && (!in_frame || !frame_ignore);
    sync_hit  = bit_tick && fsync_in && in_frame && !frame_ignore;

    // A restart discards the partial word and the frame position.
    b_phase = start ? 1'b0 : phase_q;
    b_words = start ? '0 : words_q;
    b_bits  = start ? '0 : bits_q;
    b_sh    = start ? '0 : shreg_q;

    if (start) take = bit_tick && (eff_delay == 2'd0);
    else       take = bit_tick && ((state_q == FR_DATA) ||
                                   (state_q == FR_DELAY && skip_q == 2'd0));

    cur_code   = b_phase ? wlen2_code : wlen1_code;
    cur_flen   = b_phase ? flen2_code : flen1_code;
    cur_len    = BCNT_W'(code_to_bits(3'(cur_code)));
    sh_n       = {b_sh[DATA_W-2:0], sdata_in};
    last_bit   = ((b_bits + 1'b1) == cur_len);
    last_word  = (b_words == cur_flen);
    last_phase = b_phase || !dual_phase;

    word_done   = take && last_bit;
    word_data   = sh_n;
    word_code   = cur_code;
    frame_start = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      skip_q  <= '0;
      bits_q  <= '0;
      words_q <= '0;
      phase_q <= 1'b0;
      shreg_q <= '0;
    end else if (!rx_en) begin
      state_q <= FR_IDLE;
      skip_q  <= '0;
      bits_q  <= '0;
      words_q <= '0;
      phase_q <= 1'b0;
      shreg_q <= '0;
    end else if (take) begin
      phase_q <= b_phase;
      words_q <= b_words;
      if (last_bit) begin
        shreg_q <= '0;
        bits_q  <= '0;
        if (last_word) begin
          if (last_phase) begin
            state_q <= FR_IDLE;
          end else begin
            phase_q <= 1'b1;
            words_q <= '0;
            state_q <= FR_DATA;
          end
        end else begin
          words_q <= b_words + 1'b1;
          state_q <= FR_DATA;
        end
      end else begin
        shreg_q <= sh_n;
        bits_q  <= b_bits + 1'b1;
        state_q <= FR_DATA;
      end
    end else if (start) begin
      state_q <= FR_DELAY;
      skip_q  <= eff_delay - 2'd1;
      bits_q  <= '0;
      words_q <= '0;
      phase_q <= 1'b0;
      shreg_q <= '0;
    end else if (bit_tick && state_q == FR_DELAY) begin
      skip_q <= skip_q - 2'd1;
    end
  end

endmodule

// File: rtl/fsp_rx_stage.sv
module fsp_rx_stage
  import fsp_rx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WCODE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               word_done,
  input  logic [DATA_W-1:0]  word_data,
  input  logic [WCODE_W-1:0] word_code,
  input  logic [1:0]         just_mode,
  input  logic               rd_ready,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               overrun
);

  localparam int LEN_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0]  hold_q;
  logic [WCODE_W-1:0] hold_code_q;
  logic               hold_v;
  logic [DATA_W-1:0]  out_q;
  logic               out_v;
  logic               ovr_q;
  logic               pop, move, hold_free, load, drop;

  function automatic logic [DATA_W-1:0] justify(input logic [DATA_W-1:0]  raw,
                                                input logic [WCODE_W-1:0] code,
                                                input logic [1:0]         mode);
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] hi_mask;
    len     = LEN_W'(code_to_bits(3'(code)));
    hi_mask = {DATA_W{1'b1}} << len;
    case (just_mode_t'(mode))
      JM_RIGHT_SIGN: justify = raw[len - 1'b1] ? (raw | hi_mask) : raw;
      JM_LEFT_ZERO:  justify = raw << (DATA_W - int'(len));
      default:       justify = raw;
    endcase
  endfunction

  always_comb begin
    pop       = out_v && rd_ready;
    move      = hold_v && !out_v;
    hold_free = !hold_v || move;
    load      = word_done && hold_free;
    drop      = word_done && !hold_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_code_q <= '0;
      hold_v      <= 1'b0;
      out_q       <= '0;
      out_v       <= 1'b0;
      ovr_q       <= 1'b0;
    end else if (!rx_en) begin
      hold_v <= 1'b0;
      out_v  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (move) begin
        out_q <= justify(hold_q, hold_code_q, just_mode);
        out_v <= 1'b1;
      end else if (pop) begin
        out_v <= 1'b0;
      end

      if (load) begin
        hold_q      <= word_data;
        hold_code_q <= word_code;
        hold_v      <= 1'b1;
      end else if (move) begin
        hold_v <= 1'b0;
      end

      if (drop)     ovr_q <= 1'b1;
      else if (pop) ovr_q <= 1'b0;
    end
  end

  assign rd_valid = out_v;
  assign rd_data  = out_q;
  assign overrun  = ovr_q;

endmodule

// File: rtl/fsp_rx_irq.sv
module fsp_rx_irq
  import fsp_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [1:0] irq_sel,
  input  logic       sync_hit,
  input  logic       sync_err_clr,
  input  logic       frame_start,
  input  logic       rd_valid,
  output logic       sync_err,
  output logic       irq
);

  logic sync_err_q;
  logic irq_q;
  logic irq_src;

  always_comb begin
    case (irq_src_t'(irq_sel))
      IRQ_READY: irq_src = rd_valid;
      IRQ_FRAME: irq_src = frame_start;
      IRQ_SYNC:  irq_src = sync_err_q;
      default:   irq_src = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_err_q <= 1'b0;
      irq_q      <= 1'b0;
    end else if (!rx_en) begin
      sync_err_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (sync_hit)          sync_err_q <= 1'b1;
      else if (sync_err_clr) sync_err_q <= 1'b0;
      irq_q <= irq_src;
    end
  end

  assign sync_err = sync_err_q;
  assign irq      = irq_q;

endmodule

// File: rtl/fsp_rx.sv
module fsp_rx
  import fsp_rx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FLEN_W  = 7,
  parameter int WCODE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               bit_tick,
  input  logic               fsync_in,
  input  logic               sdata_in,
  input  logic               dual_phase,
  input  logic [WCODE_W-1:0] wlen1_code,
  input  logic [WCODE_W-1:0] wlen2_code,
  input  logic [FLEN_W-1:0]  flen1_code,
  input  logic [FLEN_W-1:0]  flen2_code,
  input  logic [1:0]         delay_code,
  input  logic               frame_ignore,
  input  logic [1:0]         just_mode,
  input  logic [1:0]         irq_sel,
  input  logic               sync_err_clr,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [DATA_W-1:0]  rd_data,
  output logic               overrun,
  output logic               sync_err,
  output logic               irq
);

  logic               word_done;
  logic [DATA_W-1:0]  word_data;
  logic [WCODE_W-1:0] word_code;
  logic               frame_start;
  logic               sync_hit;

  fsp_rx_framer #(.DATA_W(DATA_W), .FLEN_W(FLEN_W), .WCODE_W(WCODE_W)) framer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .bit_tick     (bit_tick),
    .fsync_in     (fsync_in),
    .sdata_in     (sdata_in),
    .dual_phase   (dual_phase),
    .wlen1_code   (wlen1_code),
    .wlen2_code   (wlen2_code),
    .flen1_code   (flen1_code),
    .flen2_code   (flen2_code),
    .delay_code   (delay_code),
    .frame_ignore (frame_ignore),
    .word_done    (word_done),
    .word_data    (word_data),
    .word_code    (word_code),
    .frame_start  (frame_start),
    .sync_hit     (sync_hit)
  );

  fsp_rx_stage #(.DATA_W(DATA_W), .WCODE_W(WCODE_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .word_done (word_done),
    .word_data (word_data),
    .word_code (word_code),
    .just_mode (just_mode),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .overrun   (overrun)
  );

  fsp_rx_irq irq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .irq_sel      (irq_sel),
    .sync_hit     (sync_hit),
    .sync_err_clr (sync_err_clr),
    .frame_start  (frame_start),
    .rd_valid     (rd_valid),
    .sync_err     (sync_err),
    .irq          (irq)
  );

endmodule

// File: rtl/fsp_rx_chk.sv
module fsp_rx_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              bit_tick,
  input logic              fsync_in,
  input logic              frame_ignore,
  input logic [1:0]        irq_sel,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              overrun,
  input logic              sync_err,
  input logic              irq
);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rd_valid && !overrun && !sync_err));

  // R7
  sync_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> $past(bit_tick && fsync_in && !frame_ignore && rx_en));

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rd_valid));

  // R11
  irq_frame_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq_sel) == 2'd2) |-> $past(bit_tick && fsync_in));

  // R11
  irq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_sel) == 2'd1) |-> !irq);

endmodule

bind fsp_rx fsp_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .bit_tick     (bit_tick),
  .fsync_in     (fsync_in),
  .frame_ignore (frame_ignore),
  .irq_sel      (irq_sel),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_data      (rd_data),
  .overrun      (overrun),
  .sync_err     (sync_err),
  .irq          (irq)
);

// File: tb/fsp_rx_tb_top.sv
`timescale 1ns/1ps
module fsp_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        bit_tick = 1'b0;
  logic        fsync_in = 1'b0;
  logic        sdata_in = 1'b0;
  logic        dual_phase = 1'b0;
  logic [2:0]  wlen1_code = 3'd0;
  logic [2:0]  wlen2_code = 3'd0;
  logic [6:0]  flen1_code = 7'd0;
  logic [6:0]  flen2_code = 7'd0;
  logic [1:0]  delay_code = 2'd0;
  logic        frame_ignore = 1'b0;
  logic [1:0]  just_mode = 2'd0;
  logic [1:0]  irq_sel = 2'd0;
  logic        sync_err_clr = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        overrun;
  logic        sync_err;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_pulses = 0;
  logic bq[$];
  logic [31:0] got[$];

  always #4 clk = ~clk;

  fsp_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
    .fsync_in(fsync_in), .sdata_in(sdata_in), .dual_phase(dual_phase),
    .wlen1_code(wlen1_code), .wlen2_code(wlen2_code),
    .flen1_code(flen1_code), .flen2_code(flen2_code),
    .delay_code(delay_code), .frame_ignore(frame_ignore),
    .just_mode(just_mode), .irq_sel(irq_sel), .sync_err_clr(sync_err_clr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .overrun(overrun), .sync_err(sync_err), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_pulses++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] v, input int len,
                                              input int mode);
    logic [31:0] r;
    r = 32'd0;
    for (int i = 0; i < len; i++) r[i] = v[i];
    if (mode == 1) begin
      for (int i = len; i < 32; i++) r[i] = v[len-1];
    end else if (mode == 2) begin
      r = 32'd0;
      for (int i = 0; i < len; i++) r[32-len+i] = v[i];
    end
    return r;
  endfunction

  task automatic push_word(input logic [31:0] v, input int len);
    for (int i = len - 1; i >= 0; i--) bq.push_back(v[i]);
  endtask

  task automatic tick(input logic fs, input logic sd);
    @(negedge clk);
    fsync_in = fs; sdata_in = sd; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; fsync_in = 1'b0; sdata_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Sends a frame sync, d delay slots filled with ones, then the queued bits.
  task automatic play(input int d, input int extra_fs);
    int total;
    total = d + bq.size();
    for (int i = 0; i < total; i++)
      tick((i == 0) || (i == extra_fs), (i < d) ? 1'b1 : bq[i-d]);
    bq.delete();
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1);
  endtask

  task automatic pop(output logic [31:0] v, output bit ok);
    ok = 1'b0; v = 32'd0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (rd_valid) begin ok = 1'b1; break; end
    end
    if (ok) begin
      v = rd_data;
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
  endtask

  task automatic run_frame(input int d, input int extra_fs, input int nexp);
    got.delete();
    fork
      play(d, extra_fs);
      begin
        for (int k = 0; k < nexp; k++) begin
          logic [31:0] v; bit ok;
          pop(v, ok);
          if (ok) got.push_back(v);
        end
      end
    join
  endtask

  task automatic expect_empty(input string tag);
    repeat (12) @(negedge clk);
    check(!rd_valid, tag, {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic single_word(input logic [2:0] code, input int len,
                             input logic [31:0] v, input int mode, input string tag);
    wlen1_code = code; just_mode = 2'(mode); flen1_code = 7'd0; dual_phase = 1'b0;
    push_word(v, len);
    run_frame(0, -1, 1);
    check(got.size() == 1 && got[0] == expect_word(v, len, mode), tag,
          got.size() > 0 ? got[0] : 32'hx, expect_word(v, len, mode));
  endtask

  task automatic t_reset();
    check(!rd_valid && !overrun && !sync_err && !irq, "R1 reset state",
          {28'd0, rd_valid, overrun, sync_err, irq}, 32'd0);
  endtask

  task automatic t_lengths();
    single_word(3'd0, 8,  32'h000000A5, 0, "R2 8-bit MSB first");
    single_word(3'd4, 24, 32'h00ABCDEF, 0, "R2 24-bit");
    single_word(3'd5, 32, 32'hDEADBEEF, 0, "R2 32-bit");
    single_word(3'd1, 12, 32'h000009C3, 1, "R8 12-bit sign extend negative");
    single_word(3'd3, 20, 32'h0007ABCD, 1, "R8 20-bit sign extend positive");
    single_word(3'd2, 16, 32'h00001234, 2, "R8 16-bit left justify");
    single_word(3'd0, 8,  32'h000000A5, 2, "R8 8-bit left justify");
    single_word(3'd0, 8,  32'h000000F1, 3, "R8 spare mode as zero fill");
  endtask

  task automatic t_delay();
    wlen1_code = 3'd0; just_mode = 2'd0; flen1_code = 7'd0;
    for (int d = 1; d <= 3; d++) begin
      delay_code = 2'(d);
      push_word(32'h3C, 8);
      run_frame(d == 3 ? 2 : d, -1, 1);
      check(got.size() == 1 && got[0] == 32'h3C, $sformatf("R5 delay code %0d", d),
            got.size() > 0 ? got[0] : 32'hx, 32'h3C);
    end
    delay_code = 2'd0;
  endtask

  task automatic t_frame_len();
    wlen1_code = 3'd0; just_mode = 2'd0; flen1_code = 7'd2;
    push_word(32'h11, 8); push_word(32'h22, 8); push_word(32'h33, 8);
    run_frame(0, -1, 3);
    check(got.size() == 3 && got[0] == 32'h11 && got[1] == 32'h22 && got[2] == 32'h33,
          "R3 three-word frame", got.size() > 2 ? got[2] : 32'hx, 32'h33);
    idle_ticks(20);
    expect_empty("R3 idle bits after frame end");
    flen1_code = 7'd0;
  endtask

  task automatic t_dual();
    dual_phase = 1'b1; wlen1_code = 3'd0; flen1_code = 7'd1;
    wlen2_code = 3'd2; flen2_code = 7'd0; just_mode = 2'd0;
    push_word(32'h5A, 8); push_word(32'hC3, 8); push_word(32'hBEEF, 16);
    run_frame(0, -1, 3);
    check(got.size() == 3 && got[0] == 32'h5A && got[1] == 32'hC3,
          "R4 phase-1 words", got.size() > 1 ? got[1] : 32'hx, 32'hC3);
    check(got.size() == 3 && got[2] == 32'hBEEF, "R4 phase-2 16-bit word",
          got.size() > 2 ? got[2] : 32'hx, 32'hBEEF);
    idle_ticks(20);
    expect_empty("R4 frame ends after phase 2");
    dual_phase = 1'b0; flen1_code = 7'd0;
  endtask

  task automatic t_overrun();
    logic [31:0] v; bit ok;
    wlen1_code = 3'd0; flen1_code = 7'd2; just_mode = 2'd0;
    push_word(32'hA1, 8); push_word(32'hB2, 8); push_word(32'hC3, 8);
    play(0, -1);
    repeat (6) @(negedge clk);
    check(overrun == 1'b1, "R10 overrun set", {31'd0, overrun}, 32'd1);
    pop(v, ok);
    check(ok && v == 32'hA1, "R10 oldest word kept", v, 32'hA1);
    check(overrun == 1'b0, "R10 overrun cleared by read", {31'd0, overrun}, 32'd0);
    @(negedge clk);
    check(rd_valid && rd_data == 32'hB2, "R9 buffer word moves in next cycle",
          rd_data, 32'hB2);
    pop(v, ok);
    expect_empty("R10 third word lost");
    flen1_code = 7'd0;
  endtask

  task automatic t_ignore();
    wlen1_code = 3'd0; flen1_code = 7'd1; frame_ignore = 1'b1; just_mode = 2'd0;
    push_word(32'h69, 8); push_word(32'h96, 8);
    run_frame(0, 11, 2);
    check(got.size() == 2 && got[0] == 32'h69 && got[1] == 32'h96,
          "R6 ignored mid-frame sync", got.size() > 1 ? got[1] : 32'hx, 32'h96);
    check(!sync_err, "R6 no sync error", {31'd0, sync_err}, 32'd0);
    frame_ignore = 1'b0; flen1_code = 7'd0;
  endtask

  task automatic t_restart();
    wlen1_code = 3'd0; flen1_code = 7'd1; frame_ignore = 1'b0; irq_sel = 2'd3;
    bq.push_back(1'b0); bq.push_back(1'b1); bq.push_back(1'b0); bq.push_back(1'b1);
    push_word(32'h3C, 8); push_word(32'hC3, 8);
    run_frame(0, 4, 2);
    check(got.size() == 2 && got[0] == 32'h3C && got[1] == 32'hC3,
          "R7 restart discards partial word", got.size() > 0 ? got[0] : 32'hx, 32'h3C);
    check(sync_err, "R7 sync error set", {31'd0, sync_err}, 32'd1);
    check(irq, "R11 irq follows sync error", {31'd0, irq}, 32'd1);
    @(negedge clk); sync_err_clr = 1'b1;
    @(negedge clk); sync_err_clr = 1'b0;
    @(negedge clk);
    check(!sync_err && !irq, "R7 sync error cleared", {30'd0, sync_err, irq}, 32'd0);
    irq_sel = 2'd0; flen1_code = 7'd0;
  endtask

  task automatic t_irq();
    logic [31:0] v; bit ok;
    wlen1_code = 3'd0; flen1_code = 7'd0;
    irq_sel = 2'd2;
    @(negedge clk); irq_pulses = 0;
    push_word(32'h42, 8);
    run_frame(0, -1, 1);
    check(irq_pulses == 1, "R11 one pulse per frame sync", irq_pulses, 32'd1);
    irq_sel = 2'd0;
    push_word(32'h24, 8);
    play(0, -1);
    repeat (4) @(negedge clk);
    check(irq && rd_valid, "R11 irq follows ready", {30'd0, irq, rd_valid}, 32'd3);
    irq_sel = 2'd1;
    repeat (2) @(negedge clk);
    check(!irq, "R11 source 1 gives no irq", {31'd0, irq}, 32'd0);
    irq_sel = 2'd0;
    pop(v, ok);
    repeat (2) @(negedge clk);
    check(ok && v == 32'h24 && !irq, "R11 irq drops after read", v, 32'h24);
  endtask

  task automatic t_disable();
    wlen1_code = 3'd0; flen1_code = 7'd0;
    push_word(32'h77, 8);
    play(0, -1);
    repeat (4) @(negedge clk);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(!rd_valid, "R1 disable discards held word", {31'd0, rd_valid}, 32'd0);
    push_word(32'h55, 8);
    play(0, -1);
    expect_empty("R1 serial ignored while disabled");
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    expect_empty("R1 nothing left after re-enable");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    t_lengths();
    t_delay();
    t_frame_len();
    t_dual();
    t_overrun();
    t_ignore();
    t_restart();
    t_irq();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule